// File: doc/BRIEF.md
# Sampled Watchdog Trigger Decoder

This block turns the raw trigger line coming from a supervised processor into clean trigger events for a window watchdog. The line is first brought into the system clock domain through a short flop chain. After that it is looked at only when a slow sample strobe (`sample_tick`, one pulse per watchdog cycle period) is high. A trigger counts only when the samples show a falling edge that was held on both sides: two high samples, then two low samples. Shorter high or low phases are thrown away, so glitches and runt pulses never reach the watchdog.

When the second low sample completes the pattern, the block raises `trig_valid` for exactly one clock cycle. In the same cycle it presents `trig_start_idx`, the running sample number of the first of the four samples. The watchdog compares that number with its window boundaries to decide how to treat a trigger that began in one window and finished in the next. A one-cycle `hist_clr` input, driven by the power-event logic, drops any partly seen pattern.

Top module: `wd_trig_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `trig_valid` is 0 and `trig_start_idx` is 0. The sample counter restarts at 0, so the first strobe after reset takes sample number 0.
- R2: The input is evaluated only on clock edges where `sample_tick` is 1. Any amount of toggling between strobes has no effect on the output.
- R3: The pattern high, high, low, low on four consecutive samples raises `trig_valid` for exactly one cycle. That cycle is the one that follows the clock edge taking the fourth sample.
- R4: A high phase of only one sample, between low samples, never completes a trigger.
- R5: A low phase of only one sample cancels the pattern. That high sample then counts as the first high of a new pattern, so high, high, low, high, high, low, low gives one trigger, starting at the second run of highs.
- R6: When `trig_valid` is 1, `trig_start_idx` equals the fourth sample's number minus 3, modulo 2^IDX_W. Samples are numbered from 0 at reset, one per strobe. When the high phase is longer than two samples, the number refers to the last two high samples before the low.
- R7: Once a trigger has fired, a continued low level never fires again. A new trigger needs two fresh high samples followed by two low samples.
- R8: A cycle with `hist_clr` = 1 discards the partial pattern, and `trig_valid` is 0 in the following cycle. If a strobe coincides with `hist_clr`, that sample is ignored, although it still takes a sample number.
- R9: The input passes through SYNC_STAGES (default 2) flops. A level applied fewer than SYNC_STAGES clock edges before a strobe edge is not seen at that strobe. It is seen at a strobe edge SYNC_STAGES or more edges later.
- R10: The pattern is still recognised when strobes occur on consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_in | input | 1 | Raw, asynchronous trigger line |
| sample_tick | input | 1 | One-cycle strobe, once per watchdog cycle period |
| hist_clr | input | 1 | Power-event clear of the sample history |
| trig_valid | output | 1 | One-cycle pulse on a qualified trigger |
| trig_start_idx | output | IDX_W | Sample number of the first sample of the qualified pattern |

## Verification
A corrupted pattern state shows at the ports as a missing or extra `trig_valid` pulse, and no more than four strobes later, because every pattern ends at its fourth sample. A slip in the sample counter shows as a wrong `trig_start_idx` on the very next trigger. A synchronizer that is too short or too long moves the first strobe at which a new level is seen by one clock edge. Because of this, the bench places level changes exactly SYNC_STAGES edges and one edge ahead of a strobe.

// File: rtl/trigdec_pkg.sv
package trigdec_pkg;

    // pattern progress: nothing, one high, two or more highs, highs then one low
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI1  = 2'd1,
        ST_HI2  = 2'd2,
        ST_LO1  = 2'd3
    } trig_state_e;

    typedef struct packed {
        trig_state_e nxt;
        logic        fire;
    } trig_step_t;

    // one sample step of the high-high-low-low recognizer
    function automatic trig_step_t trig_step(trig_state_e cur, logic lvl);
        trig_step_t r;
        r.fire = 1'b0;
        r.nxt  = ST_IDLE;
        unique case (cur)
            ST_IDLE: r.nxt = lvl ? ST_HI1 : ST_IDLE;
            ST_HI1:  r.nxt = lvl ? ST_HI2 : ST_IDLE;
            ST_HI2:  r.nxt = lvl ? ST_HI2 : ST_LO1;
            ST_LO1: begin
                r.nxt  = lvl ? ST_HI1 : ST_IDLE;
                r.fire = ~lvl;
            end
            default: r.nxt = ST_IDLE;
        endcase
        return r;
    endfunction

    // distance from the deciding sample back to the first high of the pattern
    localparam int unsigned PATTERN_BACK = 3;

endpackage

// File: rtl/trigdec_sync.sv
module trigdec_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= 1'b0;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/trigdec_tick_counter.sv
module trigdec_tick_counter #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (tick) idx <= idx + IDX_W'(1);
    end
endmodule

// File: rtl/trigdec_pattern.sv
module trigdec_pattern
    import trigdec_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             lvl,
    input  logic [IDX_W-1:0] idx,
    output logic             valid,
    output logic [IDX_W-1:0] start_idx
);
    localparam logic [IDX_W-1:0] BACK = IDX_W'(PATTERN_BACK);

    trig_state_e state_q;
    trig_step_t  step_w;

    always_comb step_w = trig_step(state_q, lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            valid     <= 1'b0;
            start_idx <= '0;
        end else begin
            valid <= 1'b0;
            if (clr) begin
                state_q <= ST_IDLE;
            end else if (tick) begin
                state_q <= step_w.nxt;
                if (step_w.fire) begin
                    valid     <= 1'b1;
                    start_idx <= idx - BACK;
                end
            end
        end
    end
endmodule

// File: rtl/wd_trig_decoder.sv
module wd_trig_decoder #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IDX_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_in,
    input  logic             sample_tick,
    input  logic             hist_clr,
    output logic             trig_valid,
    output logic [IDX_W-1:0] trig_start_idx
);
    logic             wd_sync;
    logic [IDX_W-1:0] sample_idx;

    trigdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (wd_in),
        .q   (wd_sync)
    );

    trigdec_tick_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (sample_tick),
        .idx  (sample_idx)
    );

    trigdec_pattern #(.IDX_W(IDX_W)) u_pat (
        .clk       (clk),
        .rst       (rst),
        .clr       (hist_clr),
        .tick      (sample_tick),
        .lvl       (wd_sync),
        .idx       (sample_idx),
        .valid     (trig_valid),
        .start_idx (trig_start_idx)
    );
endmodule

// File: rtl/wd_trig_decoder_chk.sv
module wd_trig_decoder_chk #(
    parameter int unsigned IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             clr,
    input logic             lvl_sync,
    input logic             trig_valid,
    input logic [IDX_W-1:0] start_idx
);
    // independent count of strobes since reset
    logic [IDX_W-1:0] seen;
    always_ff @(posedge clk) begin
        if (rst)       seen <= '0;
        else if (tick) seen <= seen + IDX_W'(1);
    end

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig_valid |=> !trig_valid);

    // R2
    pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        trig_valid |-> $past(tick));

    // R3
    low_last_sample_chk: assert property (@(posedge clk) disable iff (rst)
        trig_valid |-> !$past(lvl_sync));

    // R8
    clr_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !trig_valid);

    // R6
    start_idx_chk: assert property (@(posedge clk) disable iff (rst)
        trig_valid |-> (start_idx == seen - IDX_W'(4)));
endmodule

bind wd_trig_decoder wd_trig_decoder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (sample_tick),
    .clr        (hist_clr),
    .lvl_sync   (wd_sync),
    .trig_valid (trig_valid),
    .start_idx  (trig_start_idx)
);

// File: tb/test_wd_trig_decoder.sv
module test_wd_trig_decoder;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned IDX_W      = 8;
    localparam int unsigned NVEC       = 29;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wd_in = 1'b0;
    logic             sample_tick = 1'b0;
    logic             hist_clr = 1'b0;
    logic             trig_valid;
    logic [IDX_W-1:0] trig_start_idx;

    int checks = 0;
    int errors = 0;
    int unsigned sidx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wd_trig_decoder #(.SYNC_STAGES(2), .IDX_W(IDX_W)) i_wd_trig_decoder (
        .clk            (clk),
        .rst            (rst),
        .wd_in          (wd_in),
        .sample_tick    (sample_tick),
        .hist_clr       (hist_clr),
        .trig_valid     (trig_valid),
        .trig_start_idx (trig_start_idx)
    );

    // vector bits: {clear before sample, sample level, expect trigger}
    localparam logic [2:0] VECS [0:NVEC-1] = '{
        3'b010, 3'b010, 3'b000, 3'b001,          // 0-3   R3 basic, start 0
        3'b000, 3'b000,                          // 4-5   R7 low continues
        3'b010, 3'b000, 3'b000,                  // 6-8   R4 single high
        3'b010, 3'b010, 3'b010, 3'b000, 3'b001,  // 9-13  R6 long high, start 10
        3'b010, 3'b010, 3'b000, 3'b010,          // 14-17 R5 single low
        3'b010, 3'b000, 3'b001,                  // 18-20 R5 trigger, start 17
        3'b010, 3'b010, 3'b100, 3'b000,          // 21-24 R8 clear mid pattern
        3'b010, 3'b010, 3'b000, 3'b001           // 25-28 R7 fresh trigger, start 25
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic take_sample(input logic lvl, input logic pre_clr);
        @(negedge clk);
        wd_in = lvl;
        if (pre_clr) begin
            hist_clr = 1'b1;
            @(negedge clk);
            hist_clr = 1'b0;
        end
        repeat (3) @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        sidx++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(trig_valid == 1'b0, "R1 valid in reset", trig_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(trig_valid == 1'b0, "R1 valid after reset", trig_valid, 0);
        check(trig_start_idx == 0, "R1 start after reset", trig_start_idx, 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            int unsigned this_idx;
            this_idx = sidx;
            take_sample(VECS[v][1], VECS[v][2]);
            check(trig_valid == VECS[v][0], "R3/R4/R5/R7/R8 pulse", trig_valid, VECS[v][0]);
            if (VECS[v][0]) begin
                check(trig_start_idx == IDX_W'(this_idx - 3), "R6 start index",
                      trig_start_idx, IDX_W'(this_idx - 3));
                @(negedge clk);
                check(trig_valid == 1'b0, "R3 single cycle", trig_valid, 0);
            end
        end

        // R2: state after H H L, toggle without strobes, then one low strobe
        take_sample(1'b1, 1'b0);
        take_sample(1'b1, 1'b0);
        take_sample(1'b0, 1'b0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            wd_in = ~wd_in;
            check(trig_valid == 1'b0, "R2 no strobe no pulse", trig_valid, 0);
        end
        begin
            int unsigned base;
            base = sidx;
            take_sample(1'b0, 1'b0);
            check(trig_valid == 1'b1, "R2 low strobe completes", trig_valid, 1);
            check(trig_start_idx == IDX_W'(base - 3), "R6 after toggling",
                  trig_start_idx, IDX_W'(base - 3));
        end

        // R9: level set one edge before strobe is not seen
        take_sample(1'b1, 1'b0);
        take_sample(1'b1, 1'b0);
        take_sample(1'b0, 1'b0);
        @(negedge clk);
        wd_in = 1'b1;               // opposite level, left long
        repeat (4) @(negedge clk);
        wd_in = 1'b0;
        sample_tick = 1'b1;         // strobe edge one edge after change
        @(negedge clk);
        sample_tick = 1'b0;
        sidx++;
        check(trig_valid == 1'b0, "R9 too-late level unseen", trig_valid, 0);
        // that sample was high: state is single high; reset pattern with lows
        take_sample(1'b0, 1'b0);
        take_sample(1'b0, 1'b0);

        // R10 and R9: four consecutive strobes, level drops with the first
        @(negedge clk);
        wd_in = 1'b1;
        repeat (4) @(negedge clk);
        begin
            int unsigned base;
            base = sidx;
            wd_in = 1'b0;
            sample_tick = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (k < 3)
                    check(trig_valid == 1'b0, "R10 no early pulse", trig_valid, 0);
            end
            sample_tick = 1'b0;
            sidx += 4;
            check(trig_valid == 1'b1, "R10 back-to-back strobes", trig_valid, 1);
            check(trig_start_idx == IDX_W'(base), "R9 two-edge latency start",
                  trig_start_idx, IDX_W'(base));
        end

        // R8: clear coinciding with a strobe ignores that sample
        take_sample(1'b1, 1'b0);
        take_sample(1'b1, 1'b0);
        take_sample(1'b0, 1'b0);
        @(negedge clk);
        hist_clr = 1'b1;
        sample_tick = 1'b1;
        @(negedge clk);
        hist_clr = 1'b0;
        sample_tick = 1'b0;
        sidx++;
        check(trig_valid == 1'b0, "R8 clear with strobe", trig_valid, 0);
        take_sample(1'b0, 1'b0);
        check(trig_valid == 1'b0, "R8 history gone", trig_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule